// File: doc/BRIEF.md
# PCI Target Address Decoder

This block sits behind a PCI target core and turns its address-phase and data-phase pulses into back-end controls. When the core raises its address-valid pulse, the block captures the address and bus command from the shared address/data and command/byte-enable lines. In that same cycle it reports, combinationally, whether the command is a user read or a user write and whether the address falls inside one of the base address windows. The window check is qualified by the memory-space or I/O-space enable bit of the configuration command register.

The core presents the address only once per burst. The block therefore keeps its own DWORD address counter and advances it on every address-increment pulse. During a decoded write it turns each increment pulse into a write strobe with per-byte enables. During a decoded read it steers the read data of the window that was hit at the start of the burst to the core.

Top module: `pci_tgt_decode`

## Requirements
- R1: In the cycle `adr_valid_i` is high, `ad_i` is captured; from the next cycle `cur_addr_o` equals it.
- R2: On each cycle with `adr_inc_i` high and `adr_valid_i` low, `cur_addr_o` grows by 4 at the next clock edge.
- R3: `rd_decode_o` is high, combinationally from `cbe_i`, exactly for the commands 4'b0010, 4'b0110, 4'b1100 and 4'b1110.
- R4: `wr_decode_o` is high exactly for 4'b0011 and 4'b0111; no command value raises both decodes.
- R5: A memory window (a BAR whose bit in `BAR_IS_IO` is 0) hits when `ad_i[31:MEM_SIZE_LOG2]` equals the same bits of its base and `mem_en_i` (command register bit 1) is high.
- R6: An I/O window hits when `ad_i[31:2]` equals base bits [31:2] and `io_en_i` (command register bit 0) is high.
- R7: `sel_o` is high only in a cycle with `adr_valid_i` high and a qualified hit on some window.
- R8: `usr_write_o` goes high the cycle after an address-valid pulse that carries a write decode and a hit, and stays high until the cycle after `last_d1_i`. `wr_strobe_o` equals `usr_write_o` AND `adr_inc_i`, with no other condition.
- R9: `wr_byte_en_o` is the inverse of the active-low `cbe_i` while `wr_strobe_o` is high, and 4'b0000 otherwise. `wr_data_o` follows `ad_i`.
- R10: `usr_read_o` goes high the cycle after an address-valid pulse with a read decode and a hit. `rd_data_o` then shows the read word of the lowest-numbered window hit in that address phase.
- R11: After reset, `cur_addr_o` is 0 and `usr_read_o` and `usr_write_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address during address phase, write data afterwards |
| cbe_i | input | 4 | Bus command during address phase, active-low byte enables afterwards |
| adr_valid_i | input | 1 | Address-phase pulse from the target core |
| adr_inc_i | input | 1 | Data-phase completion pulse |
| last_d1_i | input | 1 | Pulse one cycle after the last data phase |
| mem_en_i | input | 1 | Memory space enable (command register bit 1) |
| io_en_i | input | 1 | I/O space enable (command register bit 0) |
| bar_base_i | input | NUM_BARS*32 | Base address registers, BAR n at bits [32n+31:32n] |
| bar_rd_data_i | input | NUM_BARS*32 | Back-end read word per window |
| rd_decode_o | output | 1 | User read command decode |
| wr_decode_o | output | 1 | User write command decode |
| sel_o | output | 1 | Qualified device hit in the address phase |
| usr_read_o | output | 1 | User read burst in progress |
| usr_write_o | output | 1 | User write burst in progress |
| cur_addr_o | output | 32 | Current burst DWORD address |
| wr_strobe_o | output | 1 | Per-DWORD write strobe |
| wr_byte_en_o | output | 4 | Active-high byte enables for the strobe |
| wr_data_o | output | 32 | Write data |
| rd_data_o | output | 32 | Selected read word |

## Verification
The decodes, `sel_o`, `wr_strobe_o`, `wr_byte_en_o` and `rd_data_o` are combinational, so they are due in the cycle of the stimulus itself. The bench samples them one nanosecond after driving the inputs on the falling edge, before the next rising edge. The captured address, the burst levels and each increment of the address counter pass through one register. They are checked in the cycle after the rising edge that sampled the pulse. Increments and strobes are checked in the same low phase, against the address value from before that edge.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned BEW      = DW / 8;
  localparam int unsigned DWORD_B  = BEW;
  localparam int unsigned IO_LSB   = 2;

  typedef logic [3:0] cmd_t;
  localparam cmd_t CMD_IO_RD   = 4'b0010;
  localparam cmd_t CMD_IO_WR   = 4'b0011;
  localparam cmd_t CMD_MEM_RD  = 4'b0110;
  localparam cmd_t CMD_MEM_WR  = 4'b0111;
  localparam cmd_t CMD_MEM_RDM = 4'b1100;
  localparam cmd_t CMD_MEM_RDL = 4'b1110;
endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_tgt_pkg::*;
(
  input  logic [3:0] cmd_i,
  output logic       rd_o,
  output logic       wr_o
);
  always_comb begin
    rd_o = 1'b0;
    wr_o = 1'b0;
    unique case (cmd_i)
      CMD_IO_RD, CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: rd_o = 1'b1;
      CMD_IO_WR, CMD_MEM_WR:                           wr_o = 1'b1;
      default: ;
    endcase
  end

  // R4
  always_comb begin
    decode_excl_chk: assert (!(rd_o && wr_o));
  end
endmodule

// File: rtl/pci_bar_match.sv
module pci_bar_match
  import pci_tgt_pkg::*;
#(
  parameter int unsigned           NUM_BARS      = 2,
  parameter int unsigned           MEM_SIZE_LOG2 = 12,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO     = 2'b10,
  localparam int unsigned          IDX_W         = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic [DW-1:0]          addr_i,
  input  logic [NUM_BARS*DW-1:0] bar_base_i,
  input  logic                   mem_en_i,
  input  logic                   io_en_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [NUM_BARS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    logic [DW-1:0] base;
    assign base = bar_base_i[g*DW +: DW];
    if (BAR_IS_IO[g]) begin : g_io
      assign hit_vec[g] = io_en_i && (addr_i[DW-1:IO_LSB] == base[DW-1:IO_LSB]);
    end else begin : g_mem
      assign hit_vec[g] = mem_en_i &&
                          (addr_i[DW-1:MEM_SIZE_LOG2] == base[DW-1:MEM_SIZE_LOG2]);
    end
  end

  // lowest window index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;

  // R5 R6
  always_comb begin
    hit_needs_en_chk: assert (!hit_o || mem_en_i || io_en_i);
  end
endmodule

// File: rtl/pci_burst_addr.sv
module pci_burst_addr
  import pci_tgt_pkg::*;
#(
  parameter int unsigned IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    ad_i,
  input  logic             adr_valid_i,
  input  logic             adr_inc_i,
  input  logic             last_d1_i,
  input  logic             rd_dec_i,
  input  logic             wr_dec_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  output logic [DW-1:0]    addr_o,
  output logic             rd_act_o,
  output logic             wr_act_o,
  output logic [IDX_W-1:0] bar_idx_o
);
  logic [DW-1:0]    addr_q;
  logic             rd_act_q, wr_act_q;
  logic [IDX_W-1:0] bar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      bar_q    <= '0;
    end else if (adr_valid_i) begin
      addr_q   <= ad_i;
      rd_act_q <= rd_dec_i && hit_i;
      wr_act_q <= wr_dec_i && hit_i;
      bar_q    <= hit_idx_i;
    end else begin
      if (adr_inc_i) addr_q <= addr_q + DW'(DWORD_B);
      if (last_d1_i) begin
        rd_act_q <= 1'b0;
        wr_act_q <= 1'b0;
      end
    end
  end

  assign addr_o    = addr_q;
  assign rd_act_o  = rd_act_q;
  assign wr_act_o  = wr_act_q;
  assign bar_idx_o = bar_q;

  // R1
  addr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_valid_i |=> addr_q == $past(ad_i));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adr_inc_i && !adr_valid_i) |=> addr_q == $past(addr_q) + DW'(DWORD_B));

  // R8
  wr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_act_q) |-> $past(adr_valid_i && wr_dec_i));

  // R10
  rd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_act_q) |-> $past(adr_valid_i && rd_dec_i));
endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int unsigned         NUM_BARS      = 2,
  parameter int unsigned         MEM_SIZE_LOG2 = 12,
  parameter logic [NUM_BARS-1:0] BAR_IS_IO     = 2'b10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [31:0]            ad_i,
  input  logic [3:0]             cbe_i,
  input  logic                   adr_valid_i,
  input  logic                   adr_inc_i,
  input  logic                   last_d1_i,
  input  logic                   mem_en_i,
  input  logic                   io_en_i,
  input  logic [NUM_BARS*32-1:0] bar_base_i,
  input  logic [NUM_BARS*32-1:0] bar_rd_data_i,
  output logic                   rd_decode_o,
  output logic                   wr_decode_o,
  output logic                   sel_o,
  output logic                   usr_read_o,
  output logic                   usr_write_o,
  output logic [31:0]            cur_addr_o,
  output logic                   wr_strobe_o,
  output logic [3:0]             wr_byte_en_o,
  output logic [31:0]            wr_data_o,
  output logic [31:0]            rd_data_o
);
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1;

  logic             rd_dec, wr_dec, hit, rd_act, wr_act;
  logic [IDX_W-1:0] hit_idx, bar_idx;

  pci_cmd_decode u_cmd (
    .cmd_i (cbe_i),
    .rd_o  (rd_dec),
    .wr_o  (wr_dec)
  );

  pci_bar_match #(
    .NUM_BARS      (NUM_BARS),
    .MEM_SIZE_LOG2 (MEM_SIZE_LOG2),
    .BAR_IS_IO     (BAR_IS_IO)
  ) u_match (
    .addr_i     (ad_i),
    .bar_base_i (bar_base_i),
    .mem_en_i   (mem_en_i),
    .io_en_i    (io_en_i),
    .hit_o      (hit),
    .idx_o      (hit_idx)
  );

  pci_burst_addr #(.IDX_W(IDX_W)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ad_i        (ad_i),
    .adr_valid_i (adr_valid_i),
    .adr_inc_i   (adr_inc_i),
    .last_d1_i   (last_d1_i),
    .rd_dec_i    (rd_dec),
    .wr_dec_i    (wr_dec),
    .hit_i       (hit),
    .hit_idx_i   (hit_idx),
    .addr_o      (cur_addr_o),
    .rd_act_o    (rd_act),
    .wr_act_o    (wr_act),
    .bar_idx_o   (bar_idx)
  );

  assign rd_decode_o  = rd_dec;
  assign wr_decode_o  = wr_dec;
  assign sel_o        = adr_valid_i && hit;
  assign usr_read_o   = rd_act;
  assign usr_write_o  = wr_act;
  assign wr_strobe_o  = wr_act && adr_inc_i;
  assign wr_byte_en_o = wr_strobe_o ? ~cbe_i : 4'b0000;
  assign wr_data_o    = ad_i;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (bar_idx == IDX_W'(i)) rd_data_o = bar_rd_data_i[i*32 +: 32];
    end
  end

  // R8
  burst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(usr_read_o && usr_write_o));

  // R8
  strobe_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_d1_i && !adr_valid_i) |=> !wr_strobe_o);
endmodule

// File: tb/pci_tgt_decode_test.sv
`timescale 1ns/1ps
module pci_tgt_decode_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        adr_valid_i = 0, adr_inc_i = 0, last_d1_i = 0, mem_en_i = 0, io_en_i = 0;
  logic [63:0] bar_base_i, bar_rd_data_i;
  logic        rd_decode_o, wr_decode_o, sel_o, usr_read_o, usr_write_o, wr_strobe_o;
  logic [31:0] cur_addr_o, wr_data_o, rd_data_o;
  logic [3:0]  wr_byte_en_o;

  int checks = 0, errors = 0;

  localparam logic [31:0] MEM_BASE = 32'h8000_0000;
  localparam logic [31:0] IO_BASE  = 32'h0000_1001;
  localparam logic [31:0] RD0 = 32'hA5A5_0000, RD1 = 32'h5A5A_1111;

  assign bar_base_i    = {IO_BASE, MEM_BASE};
  assign bar_rd_data_i = {RD1, RD0};

  always #2.5 clk_i = ~clk_i;

  pci_tgt_decode uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adr_valid_i = 0; adr_inc_i = 0; last_d1_i = 0;
  endtask

  task automatic end_txn();
    @(negedge clk_i); idle(); last_d1_i = 1;
    @(negedge clk_i); idle();
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic [3:0] c);
    @(negedge clk_i); idle(); adr_valid_i = 1; ad_i = a; cbe_i = c; #1;
  endtask

  task automatic t_reset();
    #1;
    chk(cur_addr_o == 0, "R11", cur_addr_o, 0);
    chk(!usr_read_o && !usr_write_o, "R11", {usr_read_o, usr_write_o}, 0);
  endtask

  task automatic t_decode();
    @(negedge clk_i); idle();
    for (int c = 0; c < 16; c++) begin
      bit er, ew;
      cbe_i = 4'(c); #1;
      er = (c == 2) || (c == 6) || (c == 12) || (c == 14);
      ew = (c == 3) || (c == 7);
      chk(rd_decode_o == er, "R3", rd_decode_o, er);
      chk(wr_decode_o == ew, "R4", wr_decode_o, ew);
    end
  endtask

  task automatic t_mem_hit();
    mem_en_i = 1; io_en_i = 0;
    addr_phase(32'h8000_0FFC, 4'b0110);
    chk(sel_o == 1, "R5", sel_o, 1);
    addr_phase(32'h8000_1000, 4'b0110);
    chk(sel_o == 0, "R5", sel_o, 0);
    mem_en_i = 0;
    addr_phase(32'h8000_0010, 4'b0110);
    chk(sel_o == 0, "R5", sel_o, 0);
    mem_en_i = 1;
    @(negedge clk_i); idle(); ad_i = 32'h8000_0010; #1;
    chk(sel_o == 0, "R7", sel_o, 0);
    end_txn();
  endtask

  task automatic t_io_hit();
    mem_en_i = 0; io_en_i = 1;
    addr_phase(32'h0000_1003, 4'b0010);
    chk(sel_o == 1, "R6", sel_o, 1);
    addr_phase(32'h0000_1004, 4'b0010);
    chk(sel_o == 0, "R6", sel_o, 0);
    io_en_i = 0; mem_en_i = 1;
    addr_phase(32'h0000_1000, 4'b0010);
    chk(sel_o == 0, "R6", sel_o, 0);
    end_txn();
  endtask

  task automatic t_write_burst();
    mem_en_i = 1; io_en_i = 1;
    addr_phase(32'h8000_0100, 4'b0111);
    chk(sel_o && wr_decode_o, "R7", {sel_o, wr_decode_o}, 2'b11);
    @(negedge clk_i); idle(); ad_i = 32'hDEAD_0001; cbe_i = 4'b1010; #1;
    chk(cur_addr_o == 32'h8000_0100, "R1", cur_addr_o, 32'h8000_0100);
    chk(usr_write_o == 1, "R8", usr_write_o, 1);
    chk(wr_strobe_o == 0, "R8", wr_strobe_o, 0);
    chk(wr_byte_en_o == 0, "R9", wr_byte_en_o, 0);
    adr_inc_i = 1; #1;
    chk(wr_strobe_o == 1, "R8", wr_strobe_o, 1);
    chk(wr_byte_en_o == 4'b0101, "R9", wr_byte_en_o, 4'b0101);
    chk(wr_data_o == 32'hDEAD_0001, "R9", wr_data_o, 32'hDEAD_0001);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk_i); ad_i = 32'hDEAD_0000 + k; cbe_i = 4'b0000; #1;
      chk(cur_addr_o == 32'h8000_0100 + 4*k, "R2", cur_addr_o, 32'h8000_0100 + 4*k);
      chk(wr_byte_en_o == 4'hF, "R9", wr_byte_en_o, 4'hF);
    end
    @(negedge clk_i); idle(); #1;
    chk(cur_addr_o == 32'h8000_0110, "R2", cur_addr_o, 32'h8000_0110);
    @(negedge clk_i); #1;
    chk(cur_addr_o == 32'h8000_0110, "R2", cur_addr_o, 32'h8000_0110);
    last_d1_i = 1;
    @(negedge clk_i); idle(); adr_inc_i = 1; #1;
    chk(usr_write_o == 0, "R8", usr_write_o, 0);
    chk(wr_strobe_o == 0, "R8", wr_strobe_o, 0);
    @(negedge clk_i); idle();
  endtask

  task automatic t_miss_write();
    mem_en_i = 1; io_en_i = 1;
    addr_phase(32'h9000_0000, 4'b0111);
    chk(sel_o == 0, "R7", sel_o, 0);
    @(negedge clk_i); idle(); adr_inc_i = 1; #1;
    chk(usr_write_o == 0 && wr_strobe_o == 0, "R8", {usr_write_o, wr_strobe_o}, 0);
    end_txn();
  endtask

  task automatic t_read_burst();
    mem_en_i = 1; io_en_i = 1;
    addr_phase(32'h0000_1000, 4'b1100);
    chk(sel_o == 1, "R6", sel_o, 1);
    @(negedge clk_i); idle(); #1;
    chk(usr_read_o == 1 && usr_write_o == 0, "R10", {usr_read_o, usr_write_o}, 2'b10);
    chk(rd_data_o == RD1, "R10", rd_data_o, RD1);
    adr_inc_i = 1;
    @(negedge clk_i); idle(); #1;
    chk(cur_addr_o == 32'h0000_1004, "R2", cur_addr_o, 32'h0000_1004);
    chk(rd_data_o == RD1, "R10", rd_data_o, RD1);
    end_txn();
    #1;
    chk(usr_read_o == 0, "R10", usr_read_o, 0);
    addr_phase(32'h8000_0040, 4'b0110);
    @(negedge clk_i); idle(); #1;
    chk(rd_data_o == RD0 && usr_read_o, "R10", rd_data_o, RD0);
    end_txn();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_decode();
    t_mem_hit();
    t_io_hit();
    t_write_burst();
    t_miss_write();
    t_read_burst();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule